// File: doc/BRIEF.md
# Voice Group Program Sequencer

This block runs the control programs of a voice playback device. The program memory sits outside the block and is divided into 256 voice groups of equal size. The block fetches 16-bit instruction words from that memory one at a time. It executes loads into four control registers: a group pointer, a trigger-edge enable mask, a stop-pin level register and a mode register. It also executes direct jumps, jumps through the pointer register, and END. Any instruction may carry a condition, which tests either the final-repeat flag or the level of one trigger input. The audio path is handled elsewhere; this block only sequences the control program and presents the register values.

Groups 0 to 7 are the entry points for hardware trigger interrupts. After reset the block waits for a fixed power-on delay and then starts at the power-on group, which is group 32. An interrupt from the trigger block abandons whatever is in progress and restarts execution at the vectored group. This includes the power-on delay and the power-on group. The memory port is a plain request/valid read with no bound on latency.

Top module: `vg_sequencer`

## Requirements
- R1: After reset the pointer register reads 0x00, the enable mask reads 0xFF, the stop pins read 3'b111 and the mode nibble reads 4'b1111. No memory request is made.
- R2: The first memory request rises exactly POI_CYCLES clock edges after reset is released. Its address is group 32, offset 0, and the address is formed as {group, offset} with OFS_W offset bits.
- R3: An instruction word is {op[15:14], reg[13:12], cond[11:8], arg[7:0]}. op 1 is LOAD, and reg selects 0 = pointer, 1 = enable mask, 2 = stop, 3 = mode. A stop load keeps only arg[2:0], driven onto stop_pins[2:0]. A mode load keeps only arg[7:4].
- R4: While a read is outstanding, mem_req stays high and mem_addr stays unchanged until mem_valid arrives. An instruction takes effect on the edge where mem_valid is sampled, and the next word is fetched from offset+1.
- R5: op 2 is a direct jump to group {0, arg[6:0]} at offset 0; arg[7] is ignored.
- R6: op 3 jumps to the group held in the pointer register, at offset 0.
- R7: op 0 is END. It takes effect whatever its condition field holds. mem_req falls on the next edge and stays low until an interrupt arrives.
- R8: Condition code 4'b0001 executes the instruction only while last_rep is high.
- R9: A condition code with bit 3 set executes only when trig_lvl[cond[1:0]] equals cond[2]. Code 4'b0000 always executes.
- R10: Condition codes 4'b0010 to 4'b0111 never execute. A skipped instruction changes no register and execution continues at the next offset.
- R11: A mode load ignores its condition field and always executes.
- R12: irq_req is always acknowledged. The next fetch is from group {0, irq_vec}, offset 0. An instruction completing in the same cycle is discarded. The interrupt also cancels the power-on delay, and the power-on group does not run afterwards.
- R13: When a group's last word completes without jumping, execution halts and does not continue into the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Read request; high while the sequencer is running |
| mem_addr | output | 8+OFS_W | Word address {group, offset} |
| mem_valid | input | 1 | Read data valid, one cycle per word |
| mem_data | input | 16 | Instruction word |
| irq_req | input | 1 | Trigger interrupt request |
| irq_vec | input | 3 | Vector group of the interrupt |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| trig_lvl | input | 4 | Current trigger levels for conditions |
| last_rep | input | 1 | High during the final global repeat |
| r0_val | output | 8 | Group pointer register |
| en_mask | output | 8 | Trigger-edge enable mask |
| mode_bits | output | 4 | Mode register upper nibble |
| stop_pins | output | 3 | Stop output levels |

## Verification
An interrupt and the completion of a memory read can fall on the same clock edge. The interrupt must win, and the instruction being read must be dropped. To provoke this, the bench memory raises irq_req in the same cycle that it returns mem_valid for a chosen pointer load. The result is judged by the pointer register keeping its previous value while the vectored group's store to the stop pins does appear. Interrupts during the power-on delay are also checked: the power-on group must never run later.

// File: rtl/vgs_pkg.sv
// Package: shared instruction fields, encodings and reset values of the
// voice group sequencer. Assumes 16-bit instruction words.
package vgs_pkg;
    localparam int GRP_W  = 8;   // 256 voice groups
    localparam int VEC_W  = 3;   // 8 hardware vectors
    localparam int WORD_W = 16;
    localparam int TRIG_N = 4;

    typedef enum logic [1:0] {
        OP_END = 2'd0,
        OP_LD  = 2'd1,
        OP_JPD = 2'd2,
        OP_JPR = 2'd3
    } vgs_op_e;

    typedef enum logic [1:0] {
        RS_PTR  = 2'd0,
        RS_EN   = 2'd1,
        RS_STOP = 2'd2,
        RS_MODE = 2'd3
    } vgs_reg_e;

    typedef struct packed {
        vgs_op_e     op;
        vgs_reg_e    rsel;
        logic [3:0]  cond;
        logic [7:0]  arg;
    } vgs_insn_t;

    localparam logic [3:0] CND_ALWAYS = 4'h0;
    localparam logic [3:0] CND_LAST   = 4'h1;

    localparam logic [7:0] PTR_RST  = 8'h00;
    localparam logic [7:0] EN_RST   = 8'hFF;
    localparam logic [2:0] STOP_RST = 3'b111;
    localparam logic [3:0] MODE_RST = 4'hF;
endpackage

// File: rtl/vgs_cond_eval.sv
// Condition evaluator: decides whether an instruction's condition holds.
// Assumes the cond field layout of vgs_pkg; purely combinational.
module vgs_cond_eval
    import vgs_pkg::*;
#(
    parameter int NTRIG = TRIG_N
) (
    input  logic [3:0]       cond,
    input  logic             last_rep,
    input  logic [NTRIG-1:0] trig_lvl,
    output logic             cond_ok
);
    logic [NTRIG-1:0] lvl_hit;

    // one comparator per trigger: selected and at the requested level
    for (genvar i = 0; i < NTRIG; i++) begin : g_trig
        assign lvl_hit[i] = (cond[1:0] == 2'(i)) && (trig_lvl[i] == cond[2]);
    end

    // select the condition class
    always_comb begin
        if (cond[3])                  cond_ok = |lvl_hit;
        else if (cond == CND_ALWAYS)  cond_ok = 1'b1;
        else if (cond == CND_LAST)    cond_ok = last_rep;
        else                          cond_ok = 1'b0;
    end
endmodule

// File: rtl/vgs_regfile.sv
// Control register file: pointer, enable mask, stop levels and mode nibble.
// Assumes wr_en is one-hot or zero; the write takes effect on the next edge.
module vgs_regfile
    import vgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ptr_q,
    output logic [7:0] en_q,
    output logic [2:0] stop_q,
    output logic [3:0] mode_q
);
    // pointer and enable mask hold full bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_RST;
            en_q  <= EN_RST;
        end else begin
            if (wr_en[RS_PTR]) ptr_q <= wr_data;
            if (wr_en[RS_EN])  en_q  <= wr_data;
        end
    end

    // stop keeps its low three bits, mode its upper nibble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= STOP_RST;
            mode_q <= MODE_RST;
        end else begin
            if (wr_en[RS_STOP]) stop_q <= wr_data[2:0];
            if (wr_en[RS_MODE]) mode_q <= wr_data[7:4];
        end
    end

    // R3
    one_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[RS_STOP] |=> $stable(stop_q));
endmodule

// File: rtl/vgs_ctrl.sv
// Sequencer control: power-on delay, group/offset pointer, fetch handshake
// and instruction dispatch. Assumes memory holds mem_addr stable-addressed
// reads with any latency and returns one mem_valid pulse per word.
module vgs_ctrl
    import vgs_pkg::*;
#(
    parameter int OFS_W      = 4,
    parameter int POI_CYCLES = 480000,
    parameter int POI_GROUP  = 32,
    localparam int ADDR_W    = GRP_W + OFS_W,
    localparam int CNT_W     = $clog2(POI_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              cond_ok,
    input  logic [7:0]        ptr_val,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        wr_en,
    output logic [7:0]        wr_data
);
    typedef enum logic [1:0] {ST_WAIT, ST_FETCH, ST_HALT} st_e;

    st_e              st_q;
    logic [GRP_W-1:0] grp_q;
    logic [OFS_W-1:0] ofs_q;
    logic [CNT_W-1:0] cnt_q;
    vgs_insn_t        insn;
    logic             take, mode_ld, fire, is_jump, poi_done;
    logic [GRP_W-1:0] jp_tgt;

    assign insn     = vgs_insn_t'(mem_data);
    assign take     = (st_q == ST_FETCH) && mem_valid && !irq_req;
    assign mode_ld  = (insn.op == OP_LD) && (insn.rsel == RS_MODE);
    assign fire     = take && (cond_ok || mode_ld);
    assign is_jump  = (insn.op == OP_JPD) || (insn.op == OP_JPR);
    assign poi_done = (cnt_q == CNT_W'(POI_CYCLES - 1));

    // jump target: direct form drops arg[7], indirect uses the pointer
    always_comb begin
        if (insn.op == OP_JPD) jp_tgt = {1'b0, insn.arg[6:0]};
        else                   jp_tgt = ptr_val;
    end

    // register write strobes for an executed load
    always_comb begin
        wr_en   = 4'b0000;
        wr_data = insn.arg;
        if (fire && (insn.op == OP_LD)) wr_en = 4'b0001 << insn.rsel;
    end

    // power-on delay counter, counting only while waiting
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (st_q == ST_WAIT && !poi_done)   cnt_q <= cnt_q + 1'b1;
    end

    // state and program pointer; an interrupt overrides everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            grp_q <= GRP_W'(POI_GROUP);
            ofs_q <= '0;
        end else if (irq_req) begin
            st_q  <= ST_FETCH;
            grp_q <= {{(GRP_W-VEC_W){1'b0}}, irq_vec};
            ofs_q <= '0;
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (poi_done) st_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (take) begin
                        if (insn.op == OP_END) begin
                            st_q <= ST_HALT;
                        end else if (fire && is_jump) begin
                            grp_q <= jp_tgt;
                            ofs_q <= '0;
                        end else if (ofs_q == {OFS_W{1'b1}}) begin
                            st_q <= ST_HALT;
                        end else begin
                            ofs_q <= ofs_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_HALT;
            endcase
        end
    end

    assign mem_req  = (st_q == ST_FETCH);
    assign mem_addr = {grp_q, ofs_q};

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && !irq_req) |=> (mem_req && $stable(mem_addr)));

    // R13
    group_end_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ofs_q == {OFS_W{1'b1}} && insn.op == OP_LD) |=> !mem_req);
endmodule

// File: rtl/vg_sequencer.sv
// Top: voice group program sequencer. Wires the control FSM, condition
// evaluator and register file. Assumes irq_req comes from a trigger block
// that already applied the enable mask; requests are always accepted.
module vg_sequencer
    import vgs_pkg::*;
#(
    parameter int OFS_W      = 4,
    parameter int POI_CYCLES = 480000,
    parameter int POI_GROUP  = 32,
    localparam int ADDR_W    = GRP_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              irq_ack,
    input  logic [TRIG_N-1:0] trig_lvl,
    input  logic              last_rep,
    output logic [7:0]        r0_val,
    output logic [7:0]        en_mask,
    output logic [3:0]        mode_bits,
    output logic [2:0]        stop_pins
);
    logic       cond_ok;
    logic [3:0] wr_en;
    logic [7:0] wr_data;
    vgs_insn_t  insn;

    assign insn    = vgs_insn_t'(mem_data);
    assign irq_ack = irq_req;

    vgs_cond_eval #(.NTRIG(TRIG_N)) u_cond (
        .cond     (insn.cond),
        .last_rep (last_rep),
        .trig_lvl (trig_lvl),
        .cond_ok  (cond_ok)
    );

    vgs_ctrl #(
        .OFS_W      (OFS_W),
        .POI_CYCLES (POI_CYCLES),
        .POI_GROUP  (POI_GROUP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .mem_valid (mem_valid),
        .mem_data  (mem_data),
        .cond_ok   (cond_ok),
        .ptr_val   (r0_val),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    vgs_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr_q   (r0_val),
        .en_q    (en_mask),
        .stop_q  (stop_pins),
        .mode_q  (mode_bits)
    );

    // R12
    vector_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> (mem_req &&
            mem_addr == {{(GRP_W-VEC_W){1'b0}}, $past(irq_vec), {OFS_W{1'b0}}}));

    // R7
    end_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && !irq_req && insn.op == OP_END) |=> !mem_req);

    // R3
    stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && !irq_req && insn.op == OP_LD &&
         insn.rsel == RS_STOP && insn.cond == CND_ALWAYS)
        |=> (stop_pins == $past(mem_data[2:0])));
endmodule

// File: tb/vg_sequencer_tb.sv
module vg_sequencer_tb;
    localparam int OW  = 3;
    localparam int POI = 40;
    localparam int AW  = 8 + OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [15:0]   mem_data = 16'h0;
    logic          irq_t = 1'b0, irq_m = 1'b0;
    logic [2:0]    tvec = 3'd0, mvec = 3'd0;
    logic          irq_req;
    logic [2:0]    irq_vec;
    logic          irq_ack;
    logic [3:0]    trig_lvl = 4'h0;
    logic          last_rep = 1'b0;
    logic [7:0]    r0_val, en_mask;
    logic [3:0]    mode_bits;
    logic [2:0]    stop_pins;

    logic [15:0]   mem [0:(1<<AW)-1];
    int            lat = 1;
    int            wcnt = 0;
    logic [AW:0]   cur = '1;
    logic          col_en = 1'b0;
    logic [AW-1:0] col_addr = '0;
    logic [2:0]    col_vec = 3'd0;
    int            total = 0, bad = 0, cycles = 0;

    assign irq_req = irq_t | irq_m;
    assign irq_vec = irq_m ? mvec : tvec;

    always #4 clk = ~clk;

    vg_sequencer #(.OFS_W(OW), .POI_CYCLES(POI), .POI_GROUP(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .trig_lvl(trig_lvl),
        .last_rep(last_rep), .r0_val(r0_val), .en_mask(en_mask),
        .mode_bits(mode_bits), .stop_pins(stop_pins)
    );

    // memory model with programmable latency and an optional colliding interrupt
    always @(negedge clk) begin
        mem_valid = 1'b0;
        irq_m     = 1'b0;
        if (!rst_n || !mem_req) begin
            wcnt = 0;
            cur  = '1;
        end else begin
            if ({1'b0, mem_addr} != cur) begin
                cur  = {1'b0, mem_addr};
                wcnt = 0;
            end
            if (wcnt >= lat) begin
                mem_valid = 1'b1;
                mem_data  = mem[mem_addr];
                wcnt = 0;
                cur  = '1;
                if (col_en && mem_addr == col_addr) begin
                    irq_m  = 1'b1;
                    mvec   = col_vec;
                    col_en = 1'b0;
                end
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    function automatic logic [15:0] enc(input logic [1:0] op, input logic [1:0] rs,
                                        input logic [3:0] c, input logic [7:0] a);
        return {op, rs, c, a};
    endfunction

    task automatic put(input int g, input int o, input logic [15:0] d);
        mem[g * (1 << OW) + o] = d;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pulse an interrupt and wait until the program halts
    task automatic run_vec(input logic [2:0] v, output int cyc);
        @(negedge clk);
        irq_t = 1'b1;
        tvec  = v;
        @(negedge clk);
        irq_t = 1'b0;
        chk("R12 vector entry address", 32'(mem_addr), 32'(v) << OW);
        cyc = 0;
        while (mem_req && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        int n;
        logic seen;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0000;
        // power-on group
        put(32, 0, enc(2'd1, 2'd0, 4'h0, 8'h5A));
        put(32, 1, enc(2'd1, 2'd1, 4'h0, 8'h41));
        put(32, 2, enc(2'd1, 2'd2, 4'h0, 8'hFA));
        put(32, 3, enc(2'd1, 2'd3, 4'h0, 8'h3C));
        put(1, 0, enc(2'd2, 2'd0, 4'h0, 8'd40));
        put(40, 0, enc(2'd1, 2'd0, 4'h0, 8'h00));
        put(0, 0, enc(2'd2, 2'd0, 4'h0, 8'h85));
        put(0, 1, enc(2'd1, 2'd0, 4'h0, 8'hEE));
        put(5, 0, enc(2'd1, 2'd0, 4'h0, 8'h55));
        put(7, 0, enc(2'd1, 2'd0, 4'h0, 8'd200));
        put(7, 1, enc(2'd3, 2'd0, 4'h0, 8'h00));
        put(200, 0, enc(2'd1, 2'd2, 4'h0, 8'h05));
        put(6, 0, enc(2'd1, 2'd0, 4'h0, 8'h01));
        put(6, 1, enc(2'd1, 2'd0, 4'h0, 8'h02));
        put(4, 0, enc(2'd2, 2'd0, 4'h0, 8'd60));
        put(60, 0, enc(2'd1, 2'd0, 4'h0, 8'h10));
        put(60, 1, enc(2'd1, 2'd0, 4'h0, 8'h99));
        put(2, 0, enc(2'd1, 2'd2, 4'h0, 8'h03));
        put(3, 0, enc(2'd1, 2'd0, 4'h0, 8'h33));
        for (int o = 0; o < 7; o++) put(43, o, enc(2'd1, 2'd2, 4'h0, 8'h01));
        put(43, 7, enc(2'd1, 2'd0, 4'h0, 8'h42));
        put(44, 0, enc(2'd1, 2'd0, 4'h0, 8'h77));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pointer reset", 32'(r0_val), 32'h00);
        chk("R1 enable reset", 32'(en_mask), 32'hFF);
        chk("R1 stop reset", 32'(stop_pins), 32'h7);
        chk("R1 mode reset", 32'(mode_bits), 32'hF);
        chk("R1 no request", 32'(mem_req), 32'h0);
        n = 1;
        while (!mem_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R2 power-on delay", 32'(n), 32'(POI));
        chk("R2 power-on address", 32'(mem_addr), 32'(32 << OW));
        c = 0;
        while (mem_req && c < 1000) begin
            @(negedge clk);
            c++;
        end
        chk("R3 pointer load", 32'(r0_val), 32'h5A);
        chk("R3 enable load", 32'(en_mask), 32'h41);
        chk("R3 stop keeps low bits", 32'(stop_pins), 32'h2);
        chk("R3 mode keeps high nibble", 32'(mode_bits), 32'h3);

        // exhaustive trigger-level condition sweep
        for (int t = 0; t < 16; t++) begin
            for (int tr = 0; tr < 4; tr++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    trig_lvl = 4'(t);
                    lat = (t + tr + lv) % 3;
                    put(40, 1, enc(2'd1, 2'd0, {1'b1, 1'(lv), 2'(tr)}, 8'hAA));
                    run_vec(3'd1, c);
                    chk("R9 trigger level condition", 32'(r0_val),
                        (((t >> tr) & 1) == lv) ? 32'hAA : 32'h00);
                end
            end
        end

        // final-repeat condition on pointer and enable
        lat = 1;
        for (int l = 0; l < 2; l++) begin
            last_rep = 1'(l);
            put(40, 1, enc(2'd1, 2'd0, 4'h1, 8'hC3));
            run_vec(3'd1, c);
            chk("R8 last-repeat pointer load", 32'(r0_val), l ? 32'hC3 : 32'h00);
        end
        last_rep = 1'b0;
        put(40, 1, enc(2'd1, 2'd1, 4'h1, 8'h12));
        run_vec(3'd1, c);
        chk("R8 last-repeat enable skipped", 32'(en_mask), 32'h41);
        last_rep = 1'b1;
        run_vec(3'd1, c);
        chk("R8 last-repeat enable taken", 32'(en_mask), 32'h12);
        last_rep = 1'b0;

        // reserved condition codes never execute
        for (int cc = 2; cc < 8; cc++) begin
            put(40, 1, enc(2'd1, 2'd0, 4'(cc), 8'hAA));
            run_vec(3'd1, c);
            chk("R10 reserved condition skipped", 32'(r0_val), 32'h00);
        end

        // mode load ignores a false condition
        trig_lvl = 4'h0;
        put(40, 1, enc(2'd1, 2'd3, 4'hC, 8'h50));
        run_vec(3'd1, c);
        chk("R11 mode load unconditional", 32'(mode_bits), 32'h5);

        // direct jump masks arg[7]; following word not executed
        run_vec(3'd0, c);
        chk("R5 direct jump target", 32'(r0_val), 32'h55);

        // jump through the pointer register
        run_vec(3'd7, c);
        chk("R6 indirect jump target", 32'(stop_pins), 32'h5);
        chk("R6 pointer value", 32'(r0_val), 32'd200);

        // fetch timing under long latency
        lat = 4;
        run_vec(3'd6, c);
        chk("R4 busy cycles with latency 4", 32'(c), 32'd15);
        chk("R4 sequential loads", 32'(r0_val), 32'h02);
        repeat (10) @(negedge clk);
        chk("R7 halted after END", 32'(mem_req), 32'h0);

        // group end halts
        lat = 0;
        put(1, 0, enc(2'd2, 2'd0, 4'h0, 8'd43));
        run_vec(3'd1, c);
        chk("R13 halt at group end", 32'(r0_val), 32'h42);

        // interrupt colliding with a completing read
        lat = 2;
        col_en = 1'b1;
        col_addr = AW'(60 << OW) + AW'(1);
        col_vec = 3'd2;
        run_vec(3'd4, c);
        chk("R12 colliding word discarded", 32'(r0_val), 32'h10);
        chk("R12 vectored group ran", 32'(stop_pins), 32'h3);

        // interrupt during the power-on delay
        lat = 1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pointer after second reset", 32'(r0_val), 32'h00);
        repeat (4) @(negedge clk);
        run_vec(3'd3, c);
        seen = 1'b0;
        for (int k = 0; k < POI + 20; k++) begin
            @(negedge clk);
            if (mem_req) seen = 1'b1;
        end
        chk("R12 power-on group cancelled", 32'(seen), 32'h0);
        chk("R12 vector result kept", 32'(r0_val), 32'h33);
        chk("R12 stop untouched", 32'(stop_pins), 32'h7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule